// File: doc/BRIEF.md
# Register Write-Unlock Gate

This block guards the write path into a bank of clock-domain registers that are easy to corrupt. A bus master may not write a guarded register directly. It first writes a fixed key value to a dedicated key register. It then polls the top bit of the status word until it reads 1, and only then issues the guarded write. Each unlock covers exactly one guarded write. After that write is forwarded, the gate locks again. The next write needs a new key.

The gate accepts every bus write. Writes to the key offset are handled inside the gate. Writes to any other offset are treated as guarded. A guarded write goes out on the pass-through strobe, with its address and data unchanged, in the same cycle it is presented, but only if two conditions hold: the gate is unlocked and the downstream register bank reports that it is ready. When either condition is missing, the write is discarded and a sticky fault bit is raised. The unlocked state and the fault bit are read back together in one status word.

Top module: `wlock_gate`

## Requirements
- R1: After a synchronous reset, the status word is all zeros, which means locked with no fault, and the pass-through strobe is low.
- R2: A bus write to offset 0x3C with data exactly 0x0000A55A sets status bit 31. If the write is presented in cycle c, bit 31 reads 1 from cycle c+2 onward and still reads 0 in cycle c+1.
- R3: A bus write to offset 0x3C with any other data clears status bit 31, with the same two-cycle latency as R2.
- R4: A write to any offset other than 0x3C is guarded. When status bit 31 is 1 and tgt_ready is 1, the write drives prot_wr high in that same cycle, with prot_addr and prot_wdata equal to the bus address and data.
- R5: Once a guarded write has been forwarded, status bit 31 reads 0 from the next cycle on. A second guarded write without a new key is not forwarded.
- R6: A guarded write presented while status bit 31 is 0 is not forwarded, and status bit 0 reads 1 from the next cycle. Bit 0 then stays 1 until reset, even after later key writes and forwarded writes.
- R7: A guarded write presented while unlocked but with tgt_ready at 0 is not forwarded. It sets status bit 0 and leaves status bit 31 at 1.
- R8: A write to offset 0x3C never drives prot_wr, whatever its data and whatever the lock state.
- R9: When a key write's result takes effect at the same clock edge that a forwarded guarded write would relock the gate, the key result wins. Status bit 31 then reads 1 after that edge.
- R10: The status word carries the unlocked flag in bit 31 and the fault flag in bit 0. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Bus write strobe, one write per cycle |
| bus_addr | input | 6 | Bus write offset |
| bus_wdata | input | 32 | Bus write data |
| tgt_ready | input | 1 | Register bank can take a write this cycle |
| prot_wr | output | 1 | Forwarded write strobe to guarded registers |
| prot_addr | output | 6 | Forwarded write offset |
| prot_wdata | output | 32 | Forwarded write data |
| lock_status | output | 32 | Bit 31 unlocked, bit 0 sticky fault |

## Verification
The gate is driven with several kinds of write traffic. Key-then-write sequences show both the two-cycle latency and the one-shot relock. Near-miss key values (one bit off, or an extra upper bit) must not unlock it. Guarded writes sent while locked, and writes sent while unlocked but not ready, are what tell the drop-and-fault paths apart from the pass-through path. A key write placed one cycle before a forwarded write exercises the same-edge precedence. A long pseudo-random mix of key, near-key and guarded writes with a toggling ready signal is then compared every cycle against a behavioural model, so that interactions the directed cases do not reach are still covered.

// File: rtl/wlg_pkg.sv
package wlg_pkg;

    localparam int unsigned BUS_AW     = 6;
    localparam int unsigned BUS_DW     = 32;
    localparam int unsigned KEY_OFFSET = 'h3C;
    localparam int unsigned KEY_VALUE  = 'hA55A;
    localparam int unsigned KEY_LAT    = 2;

    typedef enum logic [1:0] {
        WR_IDLE    = 2'd0,
        WR_KEY     = 2'd1,
        WR_GUARDED = 2'd2
    } wr_kind_e;

    typedef struct packed {
        logic valid;
        logic match;
    } key_evt_t;

    function automatic key_evt_t key_evt_none();
        key_evt_t e;
        e.valid = 1'b0;
        e.match = 1'b0;
        return e;
    endfunction

endpackage

// File: rtl/wlg_decode.sv
module wlg_decode
    import wlg_pkg::*;
#(
    parameter int unsigned AW       = BUS_AW,
    parameter int unsigned DW       = BUS_DW,
    parameter int unsigned KEY_ADDR = KEY_OFFSET,
    parameter int unsigned KEY_VAL  = KEY_VALUE
) (
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output wr_kind_e      kind,
    output key_evt_t      evt
);

    localparam logic [AW-1:0] KEY_A = AW'(KEY_ADDR);
    localparam logic [DW-1:0] KEY_D = DW'(KEY_VAL);

    always_comb begin
        if (!wr_en) begin
            kind = WR_IDLE;
        end else if (addr == KEY_A) begin
            kind = WR_KEY;
        end else begin
            kind = WR_GUARDED;
        end
    end

    always_comb begin
        evt       = key_evt_none();
        evt.valid = (kind == WR_KEY);
        evt.match = (kind == WR_KEY) && (wdata == KEY_D);
    end

endmodule

// File: rtl/wlg_key_track.sv
module wlg_key_track
    import wlg_pkg::*;
#(
    parameter int unsigned LAT = KEY_LAT
) (
    input  logic     clk,
    input  logic     rst,
    input  key_evt_t evt_in,
    input  logic     consume,
    output logic     wen
);

    localparam int unsigned STAGES = (LAT > 1) ? LAT - 1 : 0;

    key_evt_t land;

    generate
        if (STAGES == 0) begin : g_direct
            assign land = evt_in;
        end else begin : g_pipe
            key_evt_t stage [STAGES];
            for (genvar i = 0; i < STAGES; i++) begin : g_st
                always_ff @(posedge clk) begin
                    if (rst) begin
                        stage[i] <= key_evt_none();
                    end else if (i == 0) begin
                        stage[i] <= evt_in;
                    end else begin
                        stage[i] <= stage[(i == 0) ? 0 : i - 1];
                    end
                end
            end
            assign land = stage[STAGES-1];
        end
    endgenerate

    // Key result takes precedence over the one-shot relock (R9).
    always_ff @(posedge clk) begin
        if (rst) begin
            wen <= 1'b0;
        end else if (land.valid) begin
            wen <= land.match;
        end else if (consume) begin
            wen <= 1'b0;
        end
    end

    a_r2_key_unlocks: assert property (@(posedge clk) disable iff (rst)
        land.valid && land.match |=> wen);

    a_r3_bad_key_locks: assert property (@(posedge clk) disable iff (rst)
        land.valid && !land.match |=> !wen);

    a_r5_one_shot: assert property (@(posedge clk) disable iff (rst)
        consume && !land.valid |=> !wen);

endmodule

// File: rtl/wlg_pass.sv
module wlg_pass
    import wlg_pkg::*;
#(
    parameter int unsigned AW = BUS_AW,
    parameter int unsigned DW = BUS_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  wr_kind_e      kind,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          wen,
    input  logic          tgt_ready,
    output logic          prot_wr,
    output logic [AW-1:0] prot_addr,
    output logic [DW-1:0] prot_wdata,
    output logic          consume,
    output logic          err
);

    logic guarded;
    logic drop;

    assign guarded    = (kind == WR_GUARDED);
    assign prot_wr    = guarded && wen && tgt_ready;
    assign prot_addr  = addr;
    assign prot_wdata = wdata;
    assign consume    = prot_wr;
    assign drop       = guarded && !prot_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            err <= 1'b0;
        end else if (drop) begin
            err <= 1'b1;
        end
    end

    a_r6_locked_drop_faults: assert property (@(posedge clk) disable iff (rst)
        guarded && !wen |=> err);

    a_r6_fault_sticky: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    a_r7_busy_drop_faults: assert property (@(posedge clk) disable iff (rst)
        guarded && wen && !tgt_ready |=> err);

endmodule

// File: rtl/wlock_gate.sv
module wlock_gate
    import wlg_pkg::*;
#(
    parameter int unsigned AW       = BUS_AW,
    parameter int unsigned DW       = BUS_DW,
    parameter int unsigned KEY_ADDR = KEY_OFFSET,
    parameter int unsigned KEY_VAL  = KEY_VALUE,
    parameter int unsigned LAT      = KEY_LAT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          tgt_ready,
    output logic          prot_wr,
    output logic [AW-1:0] prot_addr,
    output logic [DW-1:0] prot_wdata,
    output logic [DW-1:0] lock_status
);

    localparam int unsigned WEN_POS = DW - 1;
    localparam int unsigned ERR_POS = 0;

    wr_kind_e kind;
    key_evt_t evt;
    logic     wen;
    logic     consume;
    logic     err;

    wlg_decode #(
        .AW       (AW),
        .DW       (DW),
        .KEY_ADDR (KEY_ADDR),
        .KEY_VAL  (KEY_VAL)
    ) u_decode (
        .wr_en (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .kind  (kind),
        .evt   (evt)
    );

    wlg_key_track #(
        .LAT (LAT)
    ) u_track (
        .clk     (clk),
        .rst     (rst),
        .evt_in  (evt),
        .consume (consume),
        .wen     (wen)
    );

    wlg_pass #(
        .AW (AW),
        .DW (DW)
    ) u_pass (
        .clk        (clk),
        .rst        (rst),
        .kind       (kind),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .wen        (wen),
        .tgt_ready  (tgt_ready),
        .prot_wr    (prot_wr),
        .prot_addr  (prot_addr),
        .prot_wdata (prot_wdata),
        .consume    (consume),
        .err        (err)
    );

    always_comb begin
        lock_status          = '0;
        lock_status[WEN_POS] = wen;
        lock_status[ERR_POS] = err;
    end

    a_r8_key_not_forwarded: assert property (@(posedge clk) disable iff (rst)
        bus_wr && (bus_addr == AW'(KEY_ADDR)) |-> !prot_wr);

endmodule

// File: tb/sim_wlock_gate.sv
module sim_wlock_gate;

    localparam logic [5:0]  KEY_A = 6'h3C;
    localparam logic [31:0] KEY_D = 32'h0000_A55A;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        tgt_ready = 1'b1;
    logic        prot_wr;
    logic [5:0]  prot_addr;
    logic [31:0] prot_wdata;
    logic [31:0] lock_status;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    bit m_wen = 0;
    bit m_err = 0;
    int land_q[$];
    bit match_q[$];

    always #2 clk = ~clk;

    wlock_gate u0 (
        .clk         (clk),
        .rst         (rst),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .tgt_ready   (tgt_ready),
        .prot_wr     (prot_wr),
        .prot_addr   (prot_addr),
        .prot_wdata  (prot_wdata),
        .lock_status (lock_status)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bus_wr = 1'b0; tgt_ready = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_wen = 0; m_err = 0;
        land_q.delete(); match_q.delete();
        #1;
        chk("R1", "status after reset", lock_status, 32'h0);
        chk("R1", "strobe after reset", {31'b0, prot_wr}, 32'h0);
    endtask

    // One cycle: drive, compare against the model, then advance the model.
    task automatic step(input bit wr, input logic [5:0] a, input logic [31:0] d,
                        input bit rdy, input string tag);
        bit guarded, accept, drop, landing, lmatch;
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; tgt_ready = rdy;
        #1;
        guarded = wr && (a != KEY_A);
        accept  = guarded && m_wen && rdy;
        drop    = guarded && !accept;
        chk(tag, "prot_wr", {31'b0, prot_wr}, {31'b0, accept});
        if (accept) begin
            chk(tag, "prot_addr", {26'b0, prot_addr}, {26'b0, a});
            chk(tag, "prot_wdata", prot_wdata, d);
        end
        chk(tag, "status", lock_status, {m_wen, 30'b0, m_err});
        landing = (land_q.size() > 0) && (land_q[0] == cyc);
        lmatch  = 0;
        if (landing) begin
            lmatch = match_q[0];
            void'(land_q.pop_front());
            void'(match_q.pop_front());
        end
        if (wr && a == KEY_A) begin
            land_q.push_back(cyc + 1);
            match_q.push_back(d == KEY_D);
        end
        if (drop) m_err = 1;
        if (landing) m_wen = lmatch;
        else if (accept) m_wen = 0;
        cyc++;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 6'h0, 32'h0, 1, tag);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        do_reset();
        idle(2, "R1");

        // R2: key write, bit 31 low one cycle later, high two cycles later
        step(1, KEY_A, KEY_D, 1, "R2");
        step(0, 6'h0, 0, 1, "R2");
        chk("R2", "bit31 at c+1", {31'b0, lock_status[31]}, 32'h0);
        step(0, 6'h0, 0, 1, "R2");
        chk("R2", "bit31 at c+2", {31'b0, lock_status[31]}, 32'h1);

        // R4 forward, R5 relock, second write dropped
        step(1, 6'h04, 32'hDEAD_BEEF, 1, "R4");
        step(0, 6'h0, 0, 1, "R5");
        chk("R5", "bit31 after forward", {31'b0, lock_status[31]}, 32'h0);
        step(1, 6'h08, 32'h1234_5678, 1, "R5");
        step(0, 6'h0, 0, 1, "R6");
        chk("R6", "fault after locked write", {31'b0, lock_status[0]}, 32'h1);
        chk("R10", "status layout", lock_status, 32'h0000_0001);

        // R6 sticky across key and forward
        step(1, KEY_A, KEY_D, 1, "R6");
        idle(2, "R6");
        chk("R10", "status layout unlocked+fault", lock_status, 32'h8000_0001);
        step(1, 6'h10, 32'hA5A5_0000, 1, "R6");
        idle(3, "R6");
        chk("R6", "fault sticky", {31'b0, lock_status[0]}, 32'h1);

        // R3: near-miss keys
        do_reset();
        step(1, KEY_A, KEY_D, 1, "R3");
        idle(2, "R3");
        step(1, KEY_A, 32'h0000_A55B, 1, "R3");
        step(0, 6'h0, 0, 1, "R3");
        chk("R3", "bit31 still set at c+1", {31'b0, lock_status[31]}, 32'h1);
        step(0, 6'h0, 0, 1, "R3");
        chk("R3", "bit31 cleared at c+2", {31'b0, lock_status[31]}, 32'h0);
        step(1, KEY_A, 32'h0001_A55A, 1, "R3");
        idle(3, "R3");
        chk("R3", "upper-bit key rejected", {31'b0, lock_status[31]}, 32'h0);

        // R7: unlocked but not ready
        do_reset();
        step(1, KEY_A, KEY_D, 1, "R7");
        idle(2, "R7");
        step(1, 6'h0C, 32'hCAFE_0001, 0, "R7");
        step(0, 6'h0, 0, 1, "R7");
        chk("R7", "busy drop keeps unlock", lock_status, 32'h8000_0001);
        step(1, 6'h0C, 32'hCAFE_0002, 1, "R7");
        idle(1, "R7");

        // R8: key writes while unlocked never forward
        do_reset();
        step(1, KEY_A, KEY_D, 1, "R8");
        idle(2, "R8");
        step(1, KEY_A, KEY_D, 1, "R8");
        step(1, KEY_A, 32'hFFFF_FFFF, 1, "R8");
        idle(3, "R8");

        // R9: key lands at the same edge as a forwarded write
        do_reset();
        step(1, KEY_A, KEY_D, 1, "R9");
        idle(2, "R9");
        step(1, KEY_A, KEY_D, 1, "R9");
        step(1, 6'h14, 32'h0BAD_F00D, 1, "R9");
        step(0, 6'h0, 0, 1, "R9");
        chk("R9", "key wins over relock", {31'b0, lock_status[31]}, 32'h1);
        step(1, 6'h18, 32'h0000_0042, 1, "R9");
        idle(2, "R9");

        // Mixed traffic against the model
        do_reset();
        lfsr = 32'h1ACE_B00C;
        for (int i = 0; i < 600; i++) begin
            logic [5:0]  a;
            logic [31:0] d;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = (lfsr[3:2] != 2'b00) ? KEY_A : lfsr[9:4];
            if (a == KEY_A && lfsr[3:2] == 2'b00) a = 6'h01;
            d = lfsr[10] ? KEY_D : (lfsr[11] ? (KEY_D ^ (32'h1 << lfsr[16:12])) : lfsr);
            if (lfsr[3:2] == 2'b11) a = lfsr[9:4] == KEY_A ? 6'h02 : lfsr[9:4];
            step(lfsr[20] | lfsr[21], a, d, lfsr[22] | lfsr[23], "R4");
            if (i == 300) begin
                do_reset();
            end
        end
        idle(3, "R4");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule